// File: doc/BRIEF.md
# Register Rename Unit

This block sits after instruction decode and replaces the logical register numbers of one instruction per cycle with physical register names. A table holding one entry per logical register gives the physical register that currently holds each logical value. A circular queue of unused physical registers supplies a fresh name for every destination. The two source names are read from the table in the same cycle the instruction is presented. The destination receives the oldest free register, and the table entry for that logical destination is rewritten at the next clock edge.

The unit also reports the physical register the destination replaced. The commit logic hands that register back through a return port once the renaming instruction retires, and the returned register is queued behind those already waiting. When no free register is left, the unit raises a stall and changes nothing. The free queue runs a two-state machine. `FL_HAS` means at least one register is queued. `FL_DRY` means the queue is empty. The transition *drain* (`FL_HAS` to `FL_DRY`) happens when the last register is taken with no return in the same cycle. The transition *refill* (`FL_DRY` to `FL_HAS`) happens on any return.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i for i in 0..31. The free queue holds physical registers 32..63 in ascending order, so the first allocation returns 32.
- R2: `ren_src_a` and `ren_src_b` show, combinationally, the current table entries for `dec_src_a` and `dec_src_b`, whether or not `dec_valid` is set.
- R3: An accepted instruction (`ren_ok`=1) receives on `ren_dst` the register at the head of the free queue. The next accepted instruction receives the following queue entry.
- R4: After an accepted instruction, the table entry of its logical destination equals the `ren_dst` it was given. Source lookups from the next cycle onward show this value.
- R5: When a source equals the destination of the same instruction, the source lookup returns the mapping from before that instruction's update.
- R6: `ren_prev` shows the table entry of `dec_dst` as it was before the update.
- R7: When `dec_valid`=1 and the free queue is empty, `ren_stall`=1 and `ren_ok`=0, and neither the table nor the queue changes. Otherwise `ren_stall`=0. `ren_ok` equals `dec_valid` and not `ren_stall`.
- R8: A cycle with `ret_valid`=1 appends `ret_preg` to the tail of the free queue. It is handed out only after every register that was already queued, and a return in the same cycle does not clear a stall.
- R9: With `dec_valid`=0, neither the table nor the free queue changes; only returns act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction present this cycle |
| dec_src_a | input | 5 | First logical source |
| dec_src_b | input | 5 | Second logical source |
| dec_dst | input | 5 | Logical destination |
| ren_ok | output | 1 | Instruction accepted and renamed |
| ren_stall | output | 1 | No free register; instruction held |
| ren_src_a | output | 6 | Physical name of first source |
| ren_src_b | output | 6 | Physical name of second source |
| ren_dst | output | 6 | Newly allocated physical destination |
| ren_prev | output | 6 | Physical register the destination replaced |
| ret_valid | input | 1 | Commit returns a register this cycle |
| ret_preg | input | 6 | Physical register being returned |

## Verification
A corrupted table entry appears on `ren_src_a`, `ren_src_b` or `ren_prev` as soon as any instruction names that logical register. The bench therefore sweeps all 32 lookups after reset and after each phase. A free-queue pointer or count that is off by one shows on the very next `ren_dst`, or one or more allocations later as a duplicate name or a stall at the wrong moment. The bench catches both by comparing every output against a queue-based reference model on every cycle. Returns are interleaved with allocations, so that a tail error surfaces as soon as the queue wraps.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int LOG_REGS  = 32;
    localparam int PHYS_REGS = 64;

    typedef enum logic {
        FL_HAS = 1'b0,
        FL_DRY = 1'b1
    } fl_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int LOG_N  = 32,
    parameter int PHYS_N = 64,
    parameter int LW     = $clog2(LOG_N),
    parameter int PW     = $clog2(PHYS_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a,
    input  logic [LW-1:0] rd_b,
    input  logic [LW-1:0] rd_c,
    output logic [PW-1:0] q_a,
    output logic [PW-1:0] q_b,
    output logic [PW-1:0] q_c,
    input  logic          we,
    input  logic [LW-1:0] wa,
    input  logic [PW-1:0] wd
);
    logic [LOG_N-1:0][PW-1:0] map_q;

    // reads see the table before this cycle's write (old producer)
    always_comb begin
        q_a = map_q[rd_a];
        q_b = map_q[rd_b];
        q_c = map_q[rd_c];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LOG_N; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (we) begin
            map_q[wa] <= wd;
        end
    end

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(map_q));

    // R4
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> map_q[$past(wa)] == $past(wd));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
#(
    parameter int LOG_N  = 32,
    parameter int PHYS_N = 64,
    parameter int PW     = $clog2(PHYS_N),
    parameter int DEPTH  = PHYS_N - LOG_N,
    parameter int QW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_id,
    output logic [PW-1:0] head_id,
    output logic          empty
);
    logic [DEPTH-1:0][PW-1:0] slots_q;
    logic [QW-1:0]            head_q, tail_q;
    logic [CW-1:0]            count_q, count_d;
    fl_state_e                state_q, state_d;

    function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
        return (p == QW'(DEPTH - 1)) ? '0 : p + QW'(1);
    endfunction

    always_comb begin
        count_d = count_q;
        if (pop && !push)      count_d = count_q - CW'(1);
        else if (push && !pop) count_d = count_q + CW'(1);
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_HAS: if (count_d == '0) state_d = FL_DRY;   // drain
            FL_DRY: if (push)          state_d = FL_HAS;   // refill
            default:                   state_d = FL_HAS;
        endcase
    end

    // state and storage register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slots_q[k] <= PW'(LOG_N + k);
            end
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CW'(DEPTH);
            state_q <= (DEPTH == 0) ? FL_DRY : FL_HAS;
        end else begin
            if (push) begin
                slots_q[tail_q] <= push_id;
                tail_q          <= bump(tail_q);
            end
            if (pop) head_q <= bump(head_q);
            count_q <= count_d;
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        head_id = slots_q[head_q];
        empty   = (state_q == FL_DRY);
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> count_q < CW'(DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count_q != '0);

    // R3
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> count_q == $past(count_q) - CW'(1));

    // R7
    dry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (count_q == '0));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rn_pkg::*;
#(
    parameter  int LOG_N  = LOG_REGS,
    parameter  int PHYS_N = PHYS_REGS,
    localparam int LW     = $clog2(LOG_N),
    localparam int PW     = $clog2(PHYS_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [LW-1:0] dec_src_a,
    input  logic [LW-1:0] dec_src_b,
    input  logic [LW-1:0] dec_dst,
    output logic          ren_ok,
    output logic          ren_stall,
    output logic [PW-1:0] ren_src_a,
    output logic [PW-1:0] ren_src_b,
    output logic [PW-1:0] ren_dst,
    output logic [PW-1:0] ren_prev,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_preg
);
    logic          fl_empty;
    logic [PW-1:0] fl_head;
    logic          fire;

    always_comb begin
        ren_stall = dec_valid && fl_empty;
        fire      = dec_valid && !fl_empty;
        ren_ok    = fire;
        ren_dst   = fl_head;
    end

    rn_map_table #(
        .LOG_N (LOG_N),
        .PHYS_N(PHYS_N),
        .LW    (LW),
        .PW    (PW)
    ) u_map (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_a (dec_src_a),
        .rd_b (dec_src_b),
        .rd_c (dec_dst),
        .q_a  (ren_src_a),
        .q_b  (ren_src_b),
        .q_c  (ren_prev),
        .we   (fire),
        .wa   (dec_dst),
        .wd   (fl_head)
    );

    rn_free_list #(
        .LOG_N (LOG_N),
        .PHYS_N(PHYS_N),
        .PW    (PW)
    ) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (fire),
        .push   (ret_valid),
        .push_id(ret_preg),
        .head_id(fl_head),
        .empty  (fl_empty)
    );

    // R6
    fresh_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ok |-> ren_dst != ren_prev);
endmodule

// File: tb/sim_rename_unit.sv
module sim_rename_unit;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [4:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic       ret_valid = 1'b0;
    logic [5:0] ret_preg = '0;
    logic       ren_ok, ren_stall;
    logic [5:0] ren_src_a, ren_src_b, ren_dst, ren_prev;

    int checks = 0;
    int errors = 0;
    int model_map [32];
    int free_q [$];
    int pend_q [$];
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rename_unit u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
        .ren_ok(ren_ok), .ren_stall(ren_stall),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_dst(ren_dst), .ren_prev(ren_prev),
        .ret_valid(ret_valid), .ret_preg(ret_preg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic step(input bit v, input int a, input int b, input int d,
                        input bit rv, input int rp, input string tag_src);
        bit e_stall;
        bit e_fire;
        dec_valid = v;
        dec_src_a = 5'(a);
        dec_src_b = 5'(b);
        dec_dst   = 5'(d);
        ret_valid = rv;
        ret_preg  = 6'(rp);
        #1;
        e_stall = v && (free_q.size() == 0);
        e_fire  = v && !e_stall;
        chk("R7", "ren_stall", int'(ren_stall), int'(e_stall));
        chk("R7", "ren_ok", int'(ren_ok), int'(e_fire));
        chk((a == d) ? "R5" : tag_src, "ren_src_a", int'(ren_src_a), model_map[a]);
        chk((b == d) ? "R5" : tag_src, "ren_src_b", int'(ren_src_b), model_map[b]);
        chk("R6", "ren_prev", int'(ren_prev), model_map[d]);
        if (e_fire) chk("R3", "ren_dst", int'(ren_dst), free_q[0]);
        @(negedge clk);
        if (e_fire) begin
            pend_q.push_back(model_map[d]);
            model_map[d] = free_q.pop_front();
        end
        if (rv) free_q.push_back(rp);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++) step(1'b0, i, 31 - i, i, 1'b0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model_map[i] = i;
        for (int p = 32; p < 64; p++) free_q.push_back(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: identity map and ascending queue after reset
        sweep("R1");
        step(1'b1, 3, 4, 7, 1'b0, 0, "R1");
        chk("R1", "first alloc", int'(model_map[7]), 32);
        // R4: read back the destination just written; R5 self-reference
        step(1'b1, 7, 7, 7, 1'b0, 0, "R4");
        step(1'b1, 7, 9, 9, 1'b0, 0, "R4");
        // drain the queue completely
        for (int n = 0; n < 40; n++) begin
            int dd = (n * 7 + 3) % 32;
            step(1'b1, (dd + 5) % 32, dd, dd, 1'b0, 0, "R2");
        end
        // R7: stalled cycles change nothing; return while stalled still stalls
        step(1'b1, 1, 2, 1, 1'b0, 0, "R7");
        step(1'b1, 2, 3, 2, 1'b1, pend_q.pop_front(), "R7");
        sweep("R7");
        // R8: allocate the single returned register, then dry again
        step(1'b1, 4, 5, 6, 1'b0, 0, "R8");
        step(1'b1, 4, 6, 6, 1'b0, 0, "R8");
        // R8: several returns queued, handed out in return order
        for (int n = 0; n < 5; n++) step(1'b0, n, n, n, 1'b1, pend_q.pop_front(), "R9");
        for (int n = 0; n < 5; n++) step(1'b1, n, 10 + n, 20 + n, 1'b0, 0, "R8");
        // R9: invalid cycles with changing fields
        for (int n = 0; n < 10; n++) step(1'b0, n, n + 1, (n * 3) % 32, 1'b0, 0, "R9");
        // mixed traffic with returns, wraps the queue several times
        for (int n = 0; n < 3000; n++) begin
            bit v  = ($urandom % 4) != 0;
            bit rv = (pend_q.size() > 0) && (($urandom % 3) != 0);
            int rp = rv ? pend_q.pop_front() : 0;
            step(v, $urandom % 32, $urandom % 32, $urandom % 32, rv, rp, "R2");
        end
        sweep("R4");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule